// File: doc/BRIEF.md
# DRAM Power-Up and Refresh Scheduler

This block brings an asynchronous DRAM array out of power-up and then keeps its contents alive. After reset it holds every strobe inactive for a parameterized startup time. It then issues a preamble of dummy CAS-before-RAS cycles, and only after these does it tell the rest of the system that the memory is usable. From that point an interval timer marks when each refresh falls due. The block asks the memory-access controller for the bus through a request/grant pair and runs one CAS-before-RAS cycle per grant. Refresh and normal accesses therefore never share the strobes.

All nanosecond timing constants are turned into whole clock counts at elaboration, rounding up against the clock-period parameter. A grade parameter selects between the faster and slower timing set. A grant can arrive late, for example when the controller is inside a long page burst. Refreshes that fall due while the request waits are counted, so each one is still performed once the bus is handed over. The count saturates at its limit.

Top module: `dram_refresh_sched`

## Requirements
- R1: In reset and for at least ceil(STARTUP_NS / clock period) cycles after reset is released, `ras_n` and every bit of `cas_n` stay high (1 = inactive), `ref_req` stays 0 and `mem_ready` stays 0.
- R2: After the startup wait, exactly INIT_CYCLES (default 8) refresh cycles run without any request or grant. `mem_ready` then rises and stays 1 until reset.
- R3: In every cycle, all `cas_n` bits are low for at least ceil(5 ns / period) clock samples before `ras_n` falls (CAS-before-RAS ordering).
- R4: Once `ras_n` falls, `cas_n` stays low for at least the CAS hold time: 10 ns on the fast grade, 15 ns on the slow grade, rounded up to clocks.
- R5: `ras_n` is low for exactly max(ceil(tRAS), ceil(tCAS-hold)) clocks. tRAS is 60 ns when FAST_GRADE = 1 and 70 ns when FAST_GRADE = 0. The result never exceeds 10 µs.
- R6: Between two RAS pulses `ras_n` stays high for at least the precharge time: 40 ns on the fast grade, 50 ns on the slow grade, rounded up to clocks. The 5 ns CAS re-activation delay is covered by the same window.
- R7: The `cas_n` bits always switch together; no sample shows them unequal.
- R8: Once `mem_ready` is 1, one refresh falls due every ceil(REFRESH_NS / period) cycles. While a refresh is owed, `ref_req` is 1. No strobe moves until `ref_grant` has been sampled 1 with `ref_req` high. With an immediate grant, consecutive refreshes start exactly one interval apart.
- R9: `ref_req` stays 1 from the grant until the precharge of that refresh has ended. It then drops for at least one cycle before the next owed refresh is requested.
- R10: Refreshes that fall due while the grant is withheld are all performed once the grant returns, up to 2^DEBT_W - 1 of them (15 by default). Any further ones are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ref_grant | input | 1 | Controller hands the strobes to this block; held while `ref_req` is high |
| ref_req | output | 1 | Refresh owed, or refresh in progress, after initialization |
| mem_ready | output | 1 | Startup wait and dummy cycles complete |
| ras_n | output | 1 | Row strobe, active low (registered) |
| cas_n | output | CAS_W | Column strobes, active low, driven as a group (registered) |

## Verification
The hardest state to reach from the ports is a saturated backlog of owed refreshes. Reaching it needs the grant withheld across many intervals, followed by a check that exactly the capped number of cycles is then released. The bench drops its grant at the middle of an interval and holds it low for three intervals, and later for twenty. It re-grants at mid-interval, so no new deadline lands inside the counting window. It then counts RAS pulses and request drops in that window against 3 and against the 15-deep cap. A second instance with the slow timing set and a short startup checks that the grade parameter changes the pulse widths.

// File: rtl/dram_rfsh_pkg.sv
package dram_rfsh_pkg;

  typedef enum logic [2:0] {
    ST_BOOT,
    ST_IDLE,
    ST_REQ,
    ST_CAS,
    ST_RAS,
    ST_PRE
  } rfsh_state_e;

  // Whole clocks covering a duration in ns, never below one clock.
  function automatic int unsigned ns_to_cyc(input int unsigned ns,
                                            input int unsigned period_ps);
    int unsigned c;
    c = (ns * 1000 + period_ps - 1) / period_ps;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic int unsigned pick_grade(input bit fast,
                                             input int unsigned fast_ns,
                                             input int unsigned slow_ns);
    return fast ? fast_ns : slow_ns;
  endfunction

endpackage

// File: rtl/rfsh_period_timer.sv
module rfsh_period_timer #(
  parameter int unsigned PERIOD_C = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int unsigned CW = (PERIOD_C > 1) ? $clog2(PERIOD_C) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD_C - 1);

  logic [CW-1:0] cnt;

  assign tick = en && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!en)    cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/rfsh_debt_counter.sv
module rfsh_debt_counter #(
  parameter int unsigned W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc,
  input  logic dec,
  output logic pending
);
  localparam logic [W-1:0] FULL = '1;

  logic [W-1:0] owed;

  assign pending = (owed != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              owed <= '0;
    else if (inc && !dec && owed != FULL)    owed <= owed + 1'b1;
    else if (dec && !inc)                    owed <= owed - 1'b1;
  end

  // R10: a due refresh at the cap is dropped, count stays at the cap
  a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (owed == FULL && inc && !dec) |=> (owed == FULL));

  // R10: the sequencer never retires a refresh that was not owed
  a_r10_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    dec |-> (owed != '0));
endmodule

// File: rtl/rfsh_strobe_seq.sv
module rfsh_strobe_seq
  import dram_rfsh_pkg::*;
#(
  parameter int unsigned CAS_W  = 4,
  parameter int unsigned CSR_C  = 1,
  parameter int unsigned RASW_C = 3,
  parameter int unsigned PRE_C  = 2,
  parameter int unsigned INIT_N = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             boot_done,
  input  logic             pending,
  input  logic             gnt,
  output logic             in_boot,
  output logic             ready,
  output logic             req,
  output logic             done,
  output logic             ras_n,
  output logic [CAS_W-1:0] cas_n
);
  localparam int unsigned PMAX = max_u(max_u(CSR_C, RASW_C), PRE_C);
  localparam int unsigned PW   = $clog2(PMAX + 1);
  localparam int unsigned IW   = $clog2(INIT_N + 1);

  rfsh_state_e    state, nxt;
  logic [PW-1:0]  ph, lim;
  logic [IW-1:0]  init_cnt;
  logic           phase_last, active, ras_q, cas_q;

  assign active     = (state == ST_CAS) || (state == ST_RAS) || (state == ST_PRE);
  assign phase_last = (ph == lim);
  assign in_boot    = (state == ST_BOOT);
  assign req        = ready && (active || state == ST_REQ);
  assign done       = ready && (state == ST_PRE) && phase_last;

  always_comb begin
    unique case (state)
      ST_CAS:  lim = PW'(CSR_C - 1);
      ST_RAS:  lim = PW'(RASW_C - 1);
      default: lim = PW'(PRE_C - 1);
    endcase
  end

  always_comb begin
    nxt = state;
    unique case (state)
      ST_BOOT: if (boot_done)  nxt = ST_CAS;
      ST_IDLE: if (pending)    nxt = ST_REQ;
      ST_REQ:  if (gnt)        nxt = ST_CAS;
      ST_CAS:  if (phase_last) nxt = ST_RAS;
      ST_RAS:  if (phase_last) nxt = ST_PRE;
      ST_PRE:  if (phase_last)
                 nxt = (ready || init_cnt == IW'(INIT_N - 1)) ? ST_IDLE : ST_CAS;
      default: nxt = ST_BOOT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_BOOT;
      ph       <= '0;
      init_cnt <= '0;
      ready    <= 1'b0;
      ras_q    <= 1'b1;
      cas_q    <= 1'b1;
    end else begin
      state <= nxt;
      ras_q <= (nxt != ST_RAS);
      cas_q <= !(nxt == ST_CAS || nxt == ST_RAS);
      if (nxt != state)  ph <= '0;
      else if (active)   ph <= ph + 1'b1;
      if (state == ST_PRE && phase_last && !ready) begin
        init_cnt <= init_cnt + 1'b1;
        if (init_cnt == IW'(INIT_N - 1)) ready <= 1'b1;
      end
    end
  end

  assign ras_n = ras_q;
  for (genvar g = 0; g < CAS_W; g++) begin : g_cas
    assign cas_n[g] = cas_q;
  end

  // R3: the row strobe only falls while the column strobes were already low
  a_r3_cas_leads_ras: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_q) |-> (!cas_q && !$past(cas_q)));

  // R8: after initialization a refresh starts only on a sampled grant
  a_r8_grant_first: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && $fell(cas_q)) |-> $past(gnt));

  // R2: readiness follows the full preamble of dummy cycles
  a_r2_ready_after_init: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> (init_cnt == IW'(INIT_N)));
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
  import dram_rfsh_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_PS = 20000,
  parameter int unsigned STARTUP_NS    = 200000,
  parameter int unsigned REFRESH_NS    = 15600,
  parameter int unsigned INIT_CYCLES   = 8,
  parameter bit          FAST_GRADE    = 1'b1,
  parameter int unsigned CAS_W         = 4,
  parameter int unsigned DEBT_W        = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_grant,
  output logic             ref_req,
  output logic             mem_ready,
  output logic             ras_n,
  output logic [CAS_W-1:0] cas_n
);
  localparam int unsigned STARTUP_C = ns_to_cyc(STARTUP_NS, CLK_PERIOD_PS);
  localparam int unsigned REFRESH_C = ns_to_cyc(REFRESH_NS, CLK_PERIOD_PS);
  localparam int unsigned CSR_C     = ns_to_cyc(5, CLK_PERIOD_PS);
  localparam int unsigned CHR_C     = ns_to_cyc(pick_grade(FAST_GRADE, 10, 15), CLK_PERIOD_PS);
  localparam int unsigned TRAS_C    = ns_to_cyc(pick_grade(FAST_GRADE, 60, 70), CLK_PERIOD_PS);
  localparam int unsigned TRP_C     = ns_to_cyc(pick_grade(FAST_GRADE, 40, 50), CLK_PERIOD_PS);
  localparam int unsigned TRPC_C    = ns_to_cyc(5, CLK_PERIOD_PS);
  localparam int unsigned RASW_C    = max_u(TRAS_C, CHR_C);
  localparam int unsigned PRE_C     = max_u(TRP_C, TRPC_C);

  logic boot_tick, rfsh_tick, in_boot, pending, done;

  rfsh_period_timer #(.PERIOD_C(STARTUP_C)) boot_timer_i (
    .clk(clk), .rst_n(rst_n), .en(in_boot), .tick(boot_tick));

  rfsh_period_timer #(.PERIOD_C(REFRESH_C)) interval_timer_i (
    .clk(clk), .rst_n(rst_n), .en(mem_ready), .tick(rfsh_tick));

  rfsh_debt_counter #(.W(DEBT_W)) debt_i (
    .clk(clk), .rst_n(rst_n), .inc(rfsh_tick), .dec(done), .pending(pending));

  rfsh_strobe_seq #(
    .CAS_W(CAS_W), .CSR_C(CSR_C), .RASW_C(RASW_C), .PRE_C(PRE_C), .INIT_N(INIT_CYCLES)
  ) seq_i (
    .clk(clk), .rst_n(rst_n), .boot_done(boot_tick), .pending(pending), .gnt(ref_grant),
    .in_boot(in_boot), .ready(mem_ready), .req(ref_req), .done(done),
    .ras_n(ras_n), .cas_n(cas_n));

  // Pulse-width observers for the checks below
  logic [7:0] lo_len, hi_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_len <= '0;
      hi_len <= '1;
    end else if (ras_n) begin
      lo_len <= '0;
      if (hi_len != '1) hi_len <= hi_len + 1'b1;
    end else begin
      hi_len <= '0;
      if (lo_len != '1) lo_len <= lo_len + 1'b1;
    end
  end

  // R5: the row strobe is low for exactly the derived pulse width
  a_r5_ras_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> (lo_len == 8'(RASW_C)));

  // R6: precharge window respected before every row strobe
  a_r6_precharge: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (hi_len >= 8'(PRE_C)));

  // R9: during normal operation the request covers the whole strobe activity
  a_r9_req_covers_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_ready && (!ras_n || cas_n != '1)) |-> ref_req);

  // R1: nothing moves and nothing is ready before the startup wait ends
  a_r1_quiet_boot: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_i.in_boot) |-> (ras_n && cas_n == '1 && !ref_req && !mem_ready));
endmodule

// File: tb/dram_refresh_sched_tb_top.sv
module rfsh_strobe_mon #(
  parameter int CAS_W = 4
) (
  input  logic             clk,
  input  logic             ras_n,
  input  logic [CAS_W-1:0] cas_n,
  input  logic             req,
  output int               cyc,
  output int               pulses,
  output int               first_fall,
  output int               last_fall,
  output int               prev_fall,
  output int               min_low,
  output int               max_low,
  output int               min_high,
  output int               min_setup,
  output int               min_hold,
  output int               split,
  output int               req_falls
);
  int  low_run, high_run, cas_lo_run, hold_run;
  bit  p_ras, p_cas_lo, p_req;

  initial begin
    cyc = 0; pulses = 0; first_fall = -1; last_fall = -1; prev_fall = -1;
    min_low = 1 << 30; max_low = 0; min_high = 1 << 30;
    min_setup = 1 << 30; min_hold = 1 << 30; split = 0; req_falls = 0;
    low_run = 0; high_run = 0; cas_lo_run = 0; hold_run = 0;
    p_ras = 1; p_cas_lo = 0; p_req = 0;
  end

  always @(negedge clk) begin
    bit cas_lo;
    cyc++;
    cas_lo = (cas_n == '0);
    if (cas_n != '0 && cas_n != '1) split++;
    if (p_ras && !ras_n) begin
      pulses++;
      if (first_fall < 0) first_fall = cyc;
      if (cas_lo_run < min_setup) min_setup = cas_lo_run;
      if (pulses > 1 && high_run < min_high) min_high = high_run;
      prev_fall = last_fall;
      last_fall = cyc;
      low_run = 1;
      hold_run = cas_lo ? 1 : 0;
    end else if (!ras_n) begin
      low_run++;
      if (cas_lo) hold_run++;
    end
    if (!p_ras && ras_n) begin
      if (low_run < min_low) min_low = low_run;
      if (low_run > max_low) max_low = low_run;
      high_run = 1;
    end else if (ras_n) begin
      high_run++;
    end
    if (p_cas_lo && !cas_lo && hold_run < min_hold) min_hold = hold_run;
    cas_lo_run = cas_lo ? cas_lo_run + 1 : 0;
    if (p_req && !req) req_falls++;
    p_ras = ras_n; p_cas_lo = cas_lo; p_req = req;
  end
endmodule

module dram_refresh_sched_tb_top;
  localparam int CAS_W     = 4;
  localparam int PER_PS    = 20000;
  localparam int STARTUP_C = (200000 * 1000 + PER_PS - 1) / PER_PS; // 10000
  localparam int RC        = (15600 * 1000 + PER_PS - 1) / PER_PS;  // 780
  localparam int SLOW_BOOT = (2000 * 1000 + PER_PS - 1) / PER_PS;   // 100

  logic clk = 0;
  logic rst_n = 0;
  bit   allow = 0;
  logic ref_req, mem_ready, ras_n, ref_grant;
  logic [CAS_W-1:0] cas_n;
  logic req_s, rdy_s, ras_s;
  logic [CAS_W-1:0] cas_s;

  always #10 clk = ~clk;

  assign ref_grant = allow && ref_req;

  dram_refresh_sched #(.CLK_PERIOD_PS(PER_PS), .FAST_GRADE(1'b1), .CAS_W(CAS_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .ref_grant(ref_grant), .ref_req(ref_req),
    .mem_ready(mem_ready), .ras_n(ras_n), .cas_n(cas_n));

  dram_refresh_sched #(.CLK_PERIOD_PS(PER_PS), .STARTUP_NS(2000), .FAST_GRADE(1'b0),
                       .CAS_W(CAS_W)) dut_slow_i (
    .clk(clk), .rst_n(rst_n), .ref_grant(req_s), .ref_req(req_s),
    .mem_ready(rdy_s), .ras_n(ras_s), .cas_n(cas_s));

  int cyc, pulses, ff, lf, pf, mnl, mxl, mnh, mns, mnd, spl, rqf;
  int cyc_s, pulses_s, ff_s, lf_s, pf_s, mnl_s, mxl_s, mnh_s, mns_s, mnd_s, spl_s, rqf_s;

  rfsh_strobe_mon #(.CAS_W(CAS_W)) mon_i (
    .clk(clk), .ras_n(ras_n), .cas_n(cas_n), .req(ref_req), .cyc(cyc), .pulses(pulses),
    .first_fall(ff), .last_fall(lf), .prev_fall(pf), .min_low(mnl), .max_low(mxl),
    .min_high(mnh), .min_setup(mns), .min_hold(mnd), .split(spl), .req_falls(rqf));

  rfsh_strobe_mon #(.CAS_W(CAS_W)) mon_slow_i (
    .clk(clk), .ras_n(ras_s), .cas_n(cas_s), .req(req_s), .cyc(cyc_s), .pulses(pulses_s),
    .first_fall(ff_s), .last_fall(lf_s), .prev_fall(pf_s), .min_low(mnl_s), .max_low(mxl_s),
    .min_high(mnh_s), .min_setup(mns_s), .min_hold(mnd_s), .split(spl_s), .req_falls(rqf_s));

  int  checks = 0;
  int  failures = 0;
  bit  finished = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic wait_until(input int target);
    while (cyc < target) @(negedge clk);
  endtask

  initial begin
    int t0, tr, p0, q0;
    repeat (3) @(negedge clk);
    chk(ras_n === 1'b1, "R1", "ras_n in reset", ras_n, 1);
    chk(cas_n === '1, "R1", "cas_n in reset", cas_n, 15);
    chk(ref_req === 1'b0 && mem_ready === 1'b0, "R1", "req/ready in reset",
        {ref_req, mem_ready}, 0);
    rst_n = 1;
    t0 = cyc;
    while (!mem_ready && cyc < t0 + 20000) @(negedge clk);
    tr = cyc;
    chk(mem_ready === 1'b1, "R2", "ready reached", mem_ready, 1);
    chk(pulses == 8, "R2", "dummy cycles before ready", pulses, 8);
    chk(ff - t0 >= STARTUP_C, "R1", "first strobe after startup", ff - t0, STARTUP_C);
    chk(ff - t0 <= STARTUP_C + 4, "R1", "startup not overlong", ff - t0, STARTUP_C + 4);
    chk(rqf == 0, "R2", "no request during preamble", rqf, 0);

    // R8: immediate grant, two periodic refreshes
    allow = 1;
    while (pulses < 10 && cyc < tr + 3 * RC) @(negedge clk);
    chk(pf - tr >= RC && pf - tr <= RC + 4, "R8", "first refresh offset", pf - tr, RC);
    chk(lf - pf == RC, "R8", "refresh spacing", lf - pf, RC);

    // R8/R10: withhold grant across three deadlines
    wait_until(tr + 2 * RC + RC / 2);
    allow = 0;
    p0 = pulses; q0 = rqf;
    wait_until(tr + 5 * RC + RC / 2);
    chk(pulses == p0, "R8", "no strobe without grant", pulses - p0, 0);
    chk(ref_req === 1'b1, "R8", "request pending", ref_req, 1);
    allow = 1;
    wait_until(cyc + 300);
    chk(pulses - p0 == 3, "R10", "owed refreshes replayed", pulses - p0, 3);
    chk(rqf - q0 == 3, "R9", "request drops between refreshes", rqf - q0, 3);

    // R10: twenty deadlines missed, cap of fifteen
    wait_until(tr + 6 * RC + RC / 2);
    allow = 0;
    p0 = pulses; q0 = rqf;
    wait_until(tr + 26 * RC + RC / 2);
    chk(pulses == p0, "R8", "still no strobe without grant", pulses - p0, 0);
    allow = 1;
    wait_until(cyc + 300);
    chk(pulses - p0 == 15, "R10", "saturated backlog", pulses - p0, 15);
    chk(rqf - q0 == 15, "R9", "request drops after saturation", rqf - q0, 15);
    chk(ref_req === 1'b0, "R9", "request idle after backlog", ref_req, 0);
    chk(mem_ready === 1'b1, "R2", "ready held", mem_ready, 1);

    // Strobe shape over the whole run, fast grade
    chk(mns >= 1, "R3", "CAS-to-RAS setup", mns, 1);
    chk(mnd >= 1, "R4", "CAS hold after RAS", mnd, 1);
    chk(mnl == 3 && mxl == 3, "R5", "RAS low width fast", mxl, 3);
    chk(mnh >= 2, "R6", "precharge fast", mnh, 2);
    chk(spl == 0, "R7", "CAS bits together", spl, 0);

    // Slow grade instance
    chk(rdy_s === 1'b1, "R2", "slow ready", rdy_s, 1);
    chk(ff_s >= SLOW_BOOT + t0, "R1", "slow startup", ff_s - t0, SLOW_BOOT);
    chk(mnl_s == 4 && mxl_s == 4, "R5", "RAS low width slow", mxl_s, 4);
    chk(mnh_s >= 3, "R6", "precharge slow", mnh_s, 3);
    chk(mns_s >= 1 && mnd_s >= 1, "R4", "slow setup/hold", mnd_s, 1);
    chk(spl_s == 0, "R7", "slow CAS bits together", spl_s, 0);

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL R8 watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule